// File: doc/BRIEF.md
# Four-Function Add/Shift Unit

A purely combinational arithmetic unit. It takes two 4-bit operands and a 2-bit operation code, and returns a 4-bit result and a carry-out. One ripple adder does all the work. Operand `a_i` always drives one adder input. A 2-to-1 selector drives the other adder input with either `b_i` or `a_i`. The upper code bit goes straight into the adder carry-in.

The four operations follow from that wiring: a plain sum, an increment-sum, a left shift of `a_i` and a left shift of `a_i` with a one brought in at the bottom. Both shifts are done as `a_i + a_i`, so there is no separate shifter. The block contains no state. A host datapath places it between its own registers.

Top module: `add_shift_unit`

## Requirements
- R1: With `sel_i` = 2'b00, `{carry_o, res_o}` equals `a_i + b_i` as a 5-bit sum.
- R2: With `sel_i` = 2'b01, `res_o` equals `a_i` shifted left by one with a 0 in bit 0, and `carry_o` equals `a_i[3]`.
- R3: With `sel_i` = 2'b10, `{carry_o, res_o}` equals `a_i + b_i + 1` as a 5-bit sum.
- R4: With `sel_i` = 2'b11, `res_o` equals `{a_i[2:0], 1'b1}` and `carry_o` equals `a_i[3]`.
- R5: When `sel_i[0]` is 1, `b_i` has no effect on either output.
- R6: For the same operands and the same `sel_i[0]`, the 5-bit output with `sel_i[1]` = 1 is one more, modulo 32, than the output with `sel_i[1]` = 0.
- R7: `res_o` wraps modulo 16, and `carry_o` is the bit that leaves the 4-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand; always an adder input |
| b_i | input | 4 | Second operand; used when `sel_i[0]` is 0 |
| sel_i | input | 2 | Operation code; bit 1 is the carry-in, bit 0 picks the second adder operand |
| res_o | output | 4 | Low 4 bits of the sum |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
Two functions can act in the same evaluation: the doubling path, which selects `a_i` twice, and the carry-in increment from `sel_i[1]`. Under code 2'b11, a carry from the increment could ripple into bits that should only hold the shifted copy. The bench drives every operand pair under every code, so the all-ones and top-bit-set values of `a_i` come up together with the carry-in. For each pair it compares `res_o` and `carry_o` against a shift-or-sum model. It also sweeps `b_i` with `a_i` held fixed under the shift codes, to show that `b_i` has no effect there.

// File: rtl/asu_pkg.sv
package asu_pkg;
  localparam int unsigned ASU_WIDTH = 4;

  typedef enum logic [1:0] {
    ASU_SUM      = 2'b00,
    ASU_DBL      = 2'b01,
    ASU_SUM_INC  = 2'b10,
    ASU_DBL_INC  = 2'b11
  } asu_op_e;
endpackage

// File: rtl/asu_operand_mux.sv
module asu_operand_mux #(
  parameter int unsigned WIDTH = asu_pkg::ASU_WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             pick_a_i,
  output logic [WIDTH-1:0] opnd_o
);
  always_comb begin
    opnd_o = pick_a_i ? a_i : b_i;
  end
endmodule

// File: rtl/asu_ripple_adder.sv
module asu_ripple_adder #(
  parameter int unsigned WIDTH = asu_pkg::ASU_WIDTH
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] carry;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_fa
    logic p;
    assign p            = x_i[g] ^ y_i[g];
    assign sum_o[g]     = p ^ carry[g];
    assign carry[g+1]   = (x_i[g] & y_i[g]) | (p & carry[g]);
  end

  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/add_shift_unit.sv
module add_shift_unit #(
  parameter int unsigned WIDTH = asu_pkg::ASU_WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] opnd;

  // bit 0 doubles A (shift), bit 1 supplies the +1
  asu_operand_mux #(.WIDTH(WIDTH)) u_mux (
    .a_i      (a_i),
    .b_i      (b_i),
    .pick_a_i (sel_i[0]),
    .opnd_o   (opnd)
  );

  asu_ripple_adder #(.WIDTH(WIDTH)) u_add (
    .x_i    (a_i),
    .y_i    (opnd),
    .cin_i  (sel_i[1]),
    .sum_o  (res_o),
    .cout_o (carry_o)
  );
endmodule

// File: rtl/add_shift_unit_chk.sv
module add_shift_unit_chk #(
  parameter int unsigned WIDTH = asu_pkg::ASU_WIDTH
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       sel_i,
  input logic [WIDTH-1:0] res_o,
  input logic             carry_o
);
  localparam int unsigned W1 = WIDTH + 1;
  logic [W1-1:0] full;
  logic [W1-1:0] wide_a;
  logic [W1-1:0] wide_b;

  always_comb begin
    full   = {carry_o, res_o};
    wide_a = {1'b0, a_i};
    wide_b = {1'b0, b_i};
    if (sel_i == 2'b00) begin
      AST_SUM_PLAIN: assert (full == wide_a + wide_b); // R1
    end
    if (sel_i == 2'b01) begin
      AST_SHIFT_ZERO: assert (res_o == {a_i[WIDTH-2:0], 1'b0} && carry_o == a_i[WIDTH-1]); // R2
    end
    if (sel_i == 2'b10) begin
      AST_SUM_INC: assert (full == wide_a + wide_b + W1'(1)); // R3
    end
    if (sel_i == 2'b11) begin
      AST_SHIFT_ONE: assert (res_o == {a_i[WIDTH-2:0], 1'b1} && carry_o == a_i[WIDTH-1]); // R4
    end
    if (sel_i[0]) begin
      AST_B_UNUSED: assert (res_o[0] == sel_i[1]); // R5
    end
    AST_WRAP_CARRY: assert (full == wide_a + (sel_i[0] ? wide_a : wide_b) + W1'(sel_i[1])); // R6 R7
  end
endmodule

bind add_shift_unit add_shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .sel_i   (sel_i),
  .res_o   (res_o),
  .carry_o (carry_o)
);

// File: tb/add_shift_unit_tb.sv
module add_shift_unit_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] a_i = '0;
  logic [3:0] b_i = '0;
  logic [1:0] sel_i = '0;
  logic [3:0] res_o;
  logic       carry_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk; // 125 MHz

  add_shift_unit u_dut (
    .a_i     (a_i),
    .b_i     (b_i),
    .sel_i   (sel_i),
    .res_o   (res_o),
    .carry_o (carry_o)
  );

  // model from the requirements: shift codes form {a[2:0],cin} with carry a[3]
  function automatic int model(input int a, input int b, input int s);
    if (s[0]) return ((a & 7) << 1) | (s >> 1) | ((a >> 3) << 4);
    return a + b + (s >> 1);
  endfunction

  task automatic drive(input int a, input int b, input int s, input string tag);
    @(negedge clk);
    a_i   = a[3:0];
    b_i   = b[3:0];
    sel_i = s[1:0];
    exp_q.push_back(model(a, b, s));
    tag_q.push_back(tag);
  endtask

  // monitor: outputs settle by the next rising edge
  always @(posedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      int    e;
      string t;
      int    got;
      e   = exp_q.pop_front();
      t   = tag_q.pop_front();
      got = {27'd0, carry_o, res_o};
      checks++;
      if (got != e) begin
        errors++;
        $display("FAIL %s: sel=%b a=%0d b=%0d got=%0d exp=%0d", t, sel_i, a_i, b_i, got, e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // zero operands right after reset
    @(negedge clk);
    rst_ni = 1'b1;
    drive(0, 0, 0, "R1 zero");
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          case (s)
            0: drive(a, b, s, "R1 R7");
            1: drive(a, b, s, "R2 R7");
            2: drive(a, b, s, "R3 R6 R7");
            default: drive(a, b, s, "R4 R6 R7");
          endcase
        end
      end
    end
    // b sweep with a fixed under shift codes
    for (int s = 1; s < 4; s += 2) begin
      for (int b = 0; b < 16; b++) begin
        drive(9, b, s, "R5");
        drive(15, 15 - b, s, "R5");
      end
    end
    // wrap corners
    drive(15, 15, 2, "R7 max");
    drive(15, 0, 2, "R6 R7 carry ripple");
    drive(8, 8, 0, "R7 top carry");
    drive(15, 0, 3, "R4 all ones");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 200000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got=timeout exp=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule